// File: doc/BRIEF.md
# Carry-Pipelined Phase Accumulator

This block is the phase engine of a direct digital synthesizer. Each enabled clock cycle it adds a phase increment to a 32-bit running phase, so the phase wraps at a rate of f_clk * increment / 2^32. The top phase bit is brought out as a square wave, whose edges are at most one clock period away from ideal.

To run at a high clock rate, the 32-bit add is split into four 8-bit slices. The carry out of each slice is stored in a register before the slice above uses it, so no combinational carry path is longer than 8 bits. The upper slices therefore work on older data than the lower ones. In the default mode, the increment bits of slice s are delayed by s cycles so that a new increment reaches each slice together with the carries it produces. The slice outputs are delayed by the opposite amount, so the phase at the port is a single, coherent word. It lags a plain accumulator by exactly three enabled cycles.

Top module: `pacc_top`

## Requirements
- R1: While `rst` is high at a rising edge, `phase_o` and `sq_o` read 0 after that edge, whatever `en` and `inc_i` are.
- R2: After reset, once k enabled edges have passed, `phase_o` equals the sum modulo 2^32 of the increments sampled at enabled edges 1 to k-3. It is 0 for k of 3 or less.
- R3: The phase wraps modulo 2^32. Any carry out of bit 31 is discarded.
- R4: An edge with `en` low changes neither `phase_o` nor `sq_o`, and the `inc_i` value at that edge is ignored. Later results are as if that edge had not occurred.
- R5: R2 holds when `inc_i` changes on every enabled edge, because each increment is skewed into line with its carries.
- R6: `sq_o` equals bit 31 of `phase_o` at all times.
- R7: After an increment of 0 has been applied for at least three enabled edges, `phase_o` stays constant.
- R8: Carries cross every 8-bit slice boundary correctly, including increments of all ones (0xFFFFFFFF, which acts as minus one).
- R9: An increment of 0x40000000 gives `sq_o` a period of four enabled cycles. An increment of 0x80000000 toggles `sq_o` on every enabled cycle, the highest usable output rate of half the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; low freezes all state |
| inc_i | input | 32 | Phase increment (tuning word) |
| phase_o | output | 32 | Aligned accumulated phase |
| sq_o | output | 1 | Square-wave output, phase MSB |

## Verification
The hardest case to reach is a carry produced in a low slice while a different increment is already entering the slices above it. A mismatch appears only when the increment changes on consecutive enabled cycles and the carries ripple across several boundaries. To cover this, the stimulus feeds a new pseudo-random increment on every edge, and also runs increments of all ones so that every slice boundary carries on every cycle. Enable is dropped in the middle of a run, so the frozen skew and carry registers must resume in step.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
    // How the increment reaches each slice
    typedef enum logic {
        INC_DIRECT = 1'b0,   // all slices see inc_i in the same cycle
        INC_SKEWED = 1'b1    // slice s sees inc_i s enabled cycles late
    } inc_mode_e;
endpackage

// File: rtl/pacc_delay.sv
module pacc_delay #(
    parameter int W     = 8,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] d_o
);
    generate
        if (DEPTH == 0) begin : g_pass
            assign d_o = d_i;
        end else begin : g_line
            logic [W-1:0] stage_q [DEPTH];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int j = 0; j < DEPTH; j++) stage_q[j] <= '0;
                end else if (en) begin
                    stage_q[0] <= d_i;
                    for (int j = 1; j < DEPTH; j++) stage_q[j] <= stage_q[j-1];
                end
            end
            assign d_o = stage_q[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/pacc_slice.sv
module pacc_slice #(
    parameter int W    = 8,
    parameter bit LAST = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         cin,
    input  logic [W-1:0] inc,
    output logic [W-1:0] phase,
    output logic         cout
);
    logic [W-1:0] phase_q;

    generate
        if (LAST) begin : g_top
            // carry out of the top slice is dropped: modulo 2^PHASE_W
            logic [W-1:0] sum_w;
            assign sum_w = phase_q + inc + W'(cin);
            always_ff @(posedge clk) begin
                if (rst)     phase_q <= '0;
                else if (en) phase_q <= sum_w;
            end
            assign cout = 1'b0;
        end else begin : g_mid
            logic [W:0] sum_w;
            logic       cy_q;
            assign sum_w = {1'b0, phase_q} + {1'b0, inc} + {{W{1'b0}}, cin};
            always_ff @(posedge clk) begin
                if (rst) begin
                    phase_q <= '0;
                    cy_q    <= 1'b0;
                end else if (en) begin
                    phase_q <= sum_w[W-1:0];
                    cy_q    <= sum_w[W];
                end
            end
            assign cout = cy_q;
        end
    endgenerate

    assign phase = phase_q;
endmodule

// File: rtl/pacc_top.sv
module pacc_top
    import pacc_pkg::*;
#(
    parameter int        PHASE_W  = 32,
    parameter int        SLICE_W  = 8,
    parameter inc_mode_e INC_MODE = INC_SKEWED
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [PHASE_W-1:0] inc_i,
    output logic [PHASE_W-1:0] phase_o,
    output logic               sq_o
);
    localparam int NSL = PHASE_W / SLICE_W;
    localparam int LAT = NSL - 1;

    logic [NSL:0]         cy_chain;
    logic                 top_carry_unused;
    logic [SLICE_W-1:0]   inc_s   [NSL];
    logic [SLICE_W-1:0]   raw_s   [NSL];

    assign cy_chain[0]      = 1'b0;
    assign top_carry_unused = cy_chain[NSL];

    generate
        for (genvar s = 0; s < NSL; s++) begin : g_sl
            // increment bits for this slice
            if (INC_MODE == INC_SKEWED) begin : g_skew
                pacc_delay #(.W(SLICE_W), .DEPTH(s)) u_skew (
                    .clk (clk),
                    .rst (rst),
                    .en  (en),
                    .d_i (inc_i[s*SLICE_W +: SLICE_W]),
                    .d_o (inc_s[s])
                );
            end else begin : g_direct
                assign inc_s[s] = inc_i[s*SLICE_W +: SLICE_W];
            end

            pacc_slice #(.W(SLICE_W), .LAST(s == NSL-1)) u_slice (
                .clk   (clk),
                .rst   (rst),
                .en    (en),
                .cin   (cy_chain[s]),
                .inc   (inc_s[s]),
                .phase (raw_s[s]),
                .cout  (cy_chain[s+1])
            );

            // realign: slice s runs s cycles behind slice 0
            pacc_delay #(.W(SLICE_W), .DEPTH(LAT - s)) u_deskew (
                .clk (clk),
                .rst (rst),
                .en  (en),
                .d_i (raw_s[s]),
                .d_o (phase_o[s*SLICE_W +: SLICE_W])
            );
        end
    endgenerate

    assign sq_o = phase_o[PHASE_W-1];
endmodule

// File: rtl/pacc_chk.sv
module pacc_chk
    import pacc_pkg::*;
#(
    parameter int        PHASE_W  = 32,
    parameter int        SLICE_W  = 8,
    parameter inc_mode_e INC_MODE = INC_SKEWED
) (
    input logic               clk,
    input logic               rst,
    input logic               en,
    input logic [PHASE_W-1:0] inc_i,
    input logic [PHASE_W-1:0] phase_o,
    input logic               sq_o
);
    localparam int LAT = PHASE_W / SLICE_W - 1;

    // increments seen at past enabled edges
    logic [PHASE_W-1:0] seen_q [LAT];
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < LAT; j++) seen_q[j] <= '0;
        end else if (en) begin
            seen_q[0] <= inc_i;
            for (int j = 1; j < LAT; j++) seen_q[j] <= seen_q[j-1];
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (phase_o == '0) && !sq_o); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(phase_o) && $stable(sq_o)); // R4

    AST_ZERO_STILL: assert property (@(posedge clk) disable iff (rst)
        (en && seen_q[LAT-1] == '0) |=> $stable(phase_o)); // R7

    generate
        if (INC_MODE == INC_SKEWED) begin : g_step
            AST_STEP_MATCH: assert property (@(posedge clk) disable iff (rst)
                en |=> phase_o == PHASE_W'($past(phase_o) + $past(seen_q[LAT-1]))); // R2
        end
    endgenerate
endmodule

bind pacc_top pacc_chk #(
    .PHASE_W  (PHASE_W),
    .SLICE_W  (SLICE_W),
    .INC_MODE (INC_MODE)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .inc_i   (inc_i),
    .phase_o (phase_o),
    .sq_o    (sq_o)
);

// File: tb/pacc_top_tb.sv
module pacc_top_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b0;
    logic [31:0] inc = '0;
    logic [31:0] phase_o;
    logic        sq_o;

    int n_cmp = 0;
    int n_bad = 0;

    // reference: plain accumulator plus a history of its values
    logic [31:0] acc = '0;
    logic [31:0] h0 = '0, h1 = '0, h2 = '0, h3 = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pacc_top u_dut (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .inc_i   (inc),
        .phase_o (phase_o),
        .sq_o    (sq_o)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // one edge; called and returns at a falling edge
    task automatic tick(input logic e, input logic [31:0] v);
        en  = e;
        inc = v;
        @(posedge clk);
        if (rst) begin
            acc = '0; h0 = '0; h1 = '0; h2 = '0; h3 = '0;
        end else if (e) begin
            acc = acc + v;
            h3 = h2; h2 = h1; h1 = h0; h0 = acc;
        end
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick(1'b1, 32'hDEAD_BEEF);
        tick(1'b0, 32'h0000_0001);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        for (int i = 0; i < 3; i++) tick(1'b1, 32'h1234_5678);
        chk("R1 phase", phase_o, 32'h0);
        chk("R1 sq", {31'b0, sq_o}, 32'h0);
        rst = 1'b0;
        for (int i = 0; i < 5; i++) begin
            tick(1'b1, 32'h0101_0101);
            chk("R2 latency", phase_o, h3);
        end
    endtask

    task automatic t_constant();
        do_reset();
        for (int i = 0; i < 24; i++) begin
            tick(1'b1, 32'h0123_4567);
            chk("R2 constant", phase_o, h3);
            chk("R6 msb", {31'b0, sq_o}, {31'b0, phase_o[31]});
        end
    endtask

    task automatic t_ripple();
        do_reset();
        for (int i = 0; i < 12; i++) begin
            tick(1'b1, 32'hFFFF_FFFF);
            chk("R8 all ones", phase_o, h3);
        end
        for (int i = 0; i < 12; i++) begin
            tick(1'b1, 32'h00FF_FFFF);
            chk("R8 low ones", phase_o, h3);
        end
    endtask

    task automatic t_wrap();
        do_reset();
        for (int i = 0; i < 10; i++) begin
            tick(1'b1, 32'hC000_0001);
            chk("R3 wrap", phase_o, h3);
        end
    endtask

    task automatic t_change();
        logic [31:0] v;
        v = 32'h9E37_79B9;
        do_reset();
        for (int i = 0; i < 60; i++) begin
            v = v ^ (v << 13); v = v ^ (v >> 17); v = v ^ (v << 5);
            tick(1'b1, v);
            chk("R5 changing inc", phase_o, h3);
        end
    endtask

    task automatic t_hold();
        logic [31:0] frozen;
        do_reset();
        for (int i = 0; i < 6; i++) tick(1'b1, 32'h1357_9BDF + 32'(i));
        frozen = phase_o;
        for (int i = 0; i < 5; i++) begin
            tick(1'b0, 32'hFFFF_0000 + 32'(i));
            chk("R4 idle hold", phase_o, frozen);
        end
        for (int i = 0; i < 8; i++) begin
            tick(1'b1, 32'h0F0F_F0F0 ^ 32'(i));
            chk("R4 resume", phase_o, h3);
        end
    endtask

    task automatic t_zero();
        logic [31:0] last;
        do_reset();
        for (int i = 0; i < 5; i++) tick(1'b1, 32'h2468_ACE1);
        for (int i = 0; i < 3; i++) tick(1'b1, 32'h0);
        last = phase_o;
        for (int i = 0; i < 6; i++) begin
            tick(1'b1, 32'h0);
            chk("R7 zero inc", phase_o, last);
        end
    endtask

    task automatic t_square(input logic [31:0] v, input int exp_flips, input string rq);
        int   flips;
        logic prev;
        do_reset();
        for (int i = 0; i < 4; i++) tick(1'b1, v);
        prev  = sq_o;
        flips = 0;
        for (int i = 0; i < 16; i++) begin
            tick(1'b1, v);
            if (sq_o != prev) flips++;
            prev = sq_o;
        end
        chk(rq, 32'(flips), 32'(exp_flips));
        chk("R6 sq msb", {31'b0, sq_o}, {31'b0, h3[31]});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_constant();
        t_ripple();
        t_wrap();
        t_change();
        t_hold();
        t_zero();
        t_square(32'h4000_0000, 8,  "R9 quarter rate");
        t_square(32'h8000_0000, 16, "R9 half rate");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule